// File: doc/BRIEF.md
# Flow Tuple Hash Unit

This block turns the key of one offloaded flow into a bucket index for a hashed flow table. The caller gives a 3-bit flow-type code and up to three key buses: a source key, a destination key and a port word. Depending on the type, the unit folds the key into three 32-bit words. The key may be two MAC addresses for a bridged flow, an IPv4 address pair with packed ports, or an IPv6 address pair with packed ports. The three words then go through a select, rotate and xor chain. The last step shifts the result left by one bit, so every supported index is even and names the first slot of a two-slot bucket.

The table size is a parameter and must be a power of two. Flow types the unit cannot hash raise an error flag and return an index of all ones. Results appear one clock after `in_valid` and are held until the next request. A parameter can also select a purely combinational variant.

Type encoding (`pkt_type`): 0 IPv4 NAPT, 1 IPv4 routed, 2 bridged, 3 IPv4-in-IPv6 tunnel, 4 IPv6 3-tuple, 5 IPv6 5-tuple, 6 reserved, 7 IPv6-in-IPv4 tunnel.

Top module: `flow_hash_unit`

## Requirements
- R1: For type 2 (bridged), the source MAC is `key_src[47:0]` and the destination MAC is `key_dst[47:0]`. Each MAC has a high part (bits 47:16) and a low part (bits 15:0). The three words are A = srcLo ^ (srcHi[15:0] << 16), B = (srcHi >> 16) ^ dstLo and C = dstHi.
- R2: For types 0 and 1 (IPv4), the three words are A = `key_ports`, B = `key_dst[31:0]` and C = `key_src[31:0]`.
- R3: For types 4 and 5 (IPv6), address word k is bits [127-32k -: 32], so word 0 is the most significant. The three words are A = src3^dst3^ports, B = src2^dst2^dst0 and C = src1^dst1^src0.
- R4: The mix starts with h = (A&B)|(~A&C). The chain then rotates h left by 8 bits, applies h ^= A^B^C, then h ^= h>>16, then shifts h left by 1. The index is h masked to TABLE_ENTRIES-1, so its bit 0 is always 0 for a supported type.
- R5: For types 3, 6 and 7, `type_err` is 1 and `bucket_idx` is all ones. For every other type, `type_err` is 0.
- R6: With REGISTERED=1, `out_valid` equals `in_valid` delayed by one clock, and the index and flag shown are those of that request.
- R7: While `rst` is high (synchronous, active high), `out_valid`, `bucket_idx` and `type_err` are 0 on the next clock.
- R8: In cycles without `in_valid`, `bucket_idx` and `type_err` keep their last values.
- R9: Key bits outside the fields a type uses do not affect the index. This covers `key_src`/`key_dst` bits 127:32 for IPv4, bits 127:48 for bridged, and `key_ports` for bridged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pkt_type | input | 3 | Flow type code |
| key_src | input | 128 | Source key (MAC, IPv4 or IPv6 address) |
| key_dst | input | 128 | Destination key |
| key_ports | input | 32 | Packed port word |
| out_valid | output | 1 | Result strobe |
| bucket_idx | output | IDX_W (14) | Table bucket index |
| type_err | output | 1 | Unsupported flow type |

## Verification
The hardest behaviour to reach from the ports is the 16-bit fold of the mix. A random-looking index hides whether the upper half was xored into the lower half. It also hides whether the rotate was done in the right direction. The bench therefore uses keys that leave a single nonzero word, so that each fold stage lands on known bits. It then follows these with dense keys, checked against a model written from the word equations. For the ignored-field requirement, two requests that differ only in unused bits must give the same index.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
   typedef enum logic [2:0] {
      FT_V4_NAPT  = 3'd0,
      FT_V4_ROUTE = 3'd1,
      FT_BRIDGE   = 3'd2,
      FT_V4_IN_V6 = 3'd3,
      FT_V6_3T    = 3'd4,
      FT_V6_5T    = 3'd5,
      FT_RSVD     = 3'd6,
      FT_V6_IN_V4 = 3'd7
   } flow_type_e;

   localparam int unsigned WORD_W = 32;

   typedef struct packed {
      logic [WORD_W-1:0] a;
      logic [WORD_W-1:0] b;
      logic [WORD_W-1:0] c;
   } fold_t;
endpackage

// File: rtl/flow_key_fold.sv
module flow_key_fold
   import flow_hash_pkg::*;
#(
   parameter int unsigned KEY_W = 128
) (
   input  logic [2:0]       pkt_type,
   input  logic [KEY_W-1:0] key_src,
   input  logic [KEY_W-1:0] key_dst,
   input  logic [WORD_W-1:0] key_ports,
   output fold_t            words,
   output logic             unsupported
);
   localparam int unsigned NWORDS = KEY_W / WORD_W;

   if (KEY_W != 128) begin : g_bad_key
      $error("flow_key_fold: KEY_W must be 128");
   end

   logic [WORD_W-1:0] sw [NWORDS];
   logic [WORD_W-1:0] dw [NWORDS];

   for (genvar k = 0; k < NWORDS; k++) begin : g_split
      assign sw[k] = key_src[KEY_W-1-WORD_W*k -: WORD_W];
      assign dw[k] = key_dst[KEY_W-1-WORD_W*k -: WORD_W];
   end

   logic [31:0] smac_hi, dmac_hi;
   logic [15:0] smac_lo, dmac_lo;
   assign smac_hi = key_src[47:16];
   assign smac_lo = key_src[15:0];
   assign dmac_hi = key_dst[47:16];
   assign dmac_lo = key_dst[15:0];

   always_comb begin
      words       = '0;
      unsupported = 1'b0;
      unique case (flow_type_e'(pkt_type))
         FT_BRIDGE: begin
            words.a = {16'h0, smac_lo} ^ {smac_hi[15:0], 16'h0};
            words.b = {16'h0, smac_hi[31:16]} ^ {16'h0, dmac_lo};
            words.c = dmac_hi;
         end
         FT_V4_NAPT, FT_V4_ROUTE: begin
            words.a = key_ports;
            words.b = key_dst[31:0];
            words.c = key_src[31:0];
         end
         FT_V6_3T, FT_V6_5T: begin
            words.a = sw[3] ^ dw[3] ^ key_ports;
            words.b = sw[2] ^ dw[2] ^ dw[0];
            words.c = sw[1] ^ dw[1] ^ sw[0];
         end
         default: unsupported = 1'b1;
      endcase
   end
endmodule

// File: rtl/flow_hash_mix.sv
module flow_hash_mix
   import flow_hash_pkg::*;
#(
   parameter int unsigned IDX_W = 14
) (
   input  fold_t             words,
   output logic [IDX_W-1:0]  idx
);
   logic [WORD_W-1:0] sel, rot, mixed, folded, shifted;

   always_comb begin
      sel     = (words.a & words.b) | (~words.a & words.c);
      rot     = {sel[WORD_W-9:0], sel[WORD_W-1 -: 8]};
      mixed   = rot ^ words.a ^ words.b ^ words.c;
      folded  = mixed ^ (mixed >> 16);
      shifted = folded << 1;
   end

   assign idx = shifted[IDX_W-1:0];
endmodule

// File: rtl/flow_hash_unit.sv
module flow_hash_unit
   import flow_hash_pkg::*;
#(
   parameter int unsigned TABLE_ENTRIES = 16384,
   parameter bit          REGISTERED    = 1'b1,
   localparam int unsigned IDX_W        = $clog2(TABLE_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [2:0]       pkt_type,
   input  logic [127:0]     key_src,
   input  logic [127:0]     key_dst,
   input  logic [31:0]      key_ports,
   output logic             out_valid,
   output logic [IDX_W-1:0] bucket_idx,
   output logic             type_err
);
   if ((TABLE_ENTRIES & (TABLE_ENTRIES - 1)) != 0) begin : g_bad_pow2
      $error("flow_hash_unit: TABLE_ENTRIES must be a power of two");
   end
   if (IDX_W < 2 || IDX_W > WORD_W) begin : g_bad_size
      $error("flow_hash_unit: TABLE_ENTRIES out of range");
   end

   fold_t            words;
   logic             unsup;
   logic [IDX_W-1:0] mix_idx;
   logic [IDX_W-1:0] idx_next;

   flow_key_fold #(.KEY_W(128)) u_fold (
      .pkt_type    (pkt_type),
      .key_src     (key_src),
      .key_dst     (key_dst),
      .key_ports   (key_ports),
      .words       (words),
      .unsupported (unsup)
   );

   flow_hash_mix #(.IDX_W(IDX_W)) u_mix (
      .words (words),
      .idx   (mix_idx)
   );

   assign idx_next = unsup ? {IDX_W{1'b1}} : mix_idx;

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid  <= 1'b0;
            bucket_idx <= '0;
            type_err   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               bucket_idx <= idx_next;
               type_err   <= unsup;
            end
         end
      end
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign bucket_idx = idx_next;
      assign type_err   = unsup;
   end
endmodule

// File: rtl/flow_hash_chk.sv
module flow_hash_chk #(
   parameter int unsigned IDX_W = 14,
   parameter bit          REG   = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [2:0]       pkt_type,
   input logic             out_valid,
   input logic [IDX_W-1:0] bucket_idx,
   input logic             type_err
);
   // R4: supported results land on an even slot
   p_even_idx_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !type_err) |-> (bucket_idx[0] == 1'b0));

   // R5: error results carry an all-ones index
   p_err_ones_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && type_err) |-> (&bucket_idx));

   if (REG) begin : g_seq
      // R5: unsupported codes raise the flag on the next clock
      p_err_type_r5: assert property (@(posedge clk) disable iff (rst)
         (in_valid && (pkt_type == 3'd3 || pkt_type == 3'd6 || pkt_type == 3'd7))
         |=> type_err);
      // R6: one-cycle latency
      p_latency_r6: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      // R8: hold between requests
      p_hold_r8: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> ($stable(bucket_idx) && $stable(type_err)));
   end
endmodule

bind flow_hash_unit flow_hash_chk #(.IDX_W(IDX_W), .REG(REGISTERED)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .pkt_type   (pkt_type),
   .out_valid  (out_valid),
   .bucket_idx (bucket_idx),
   .type_err   (type_err)
);

// File: tb/test_flow_hash_unit.sv
module test_flow_hash_unit;
   localparam int CLK_PERIOD = 10;
   localparam int ENTRIES    = 16384;
   localparam int IW         = 14;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [2:0]    pkt_type = '0;
   logic [127:0]  key_src = '0;
   logic [127:0]  key_dst = '0;
   logic [31:0]   key_ports = '0;
   logic          out_valid;
   logic [IW-1:0] bucket_idx;
   logic          type_err;

   int checks = 0;
   int failures = 0;
   logic [IW-1:0] saved;

   always #(CLK_PERIOD/2) clk = ~clk;

   flow_hash_unit i_flow_hash_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .pkt_type(pkt_type),
      .key_src(key_src), .key_dst(key_dst), .key_ports(key_ports),
      .out_valid(out_valid), .bucket_idx(bucket_idx), .type_err(type_err)
   );

   function automatic logic [IW-1:0] ref_mix(logic [31:0] a, logic [31:0] b, logic [31:0] c);
      logic [31:0] h;
      h = (a & b) | (~a & c);
      h = (h << 8) | (h >> 24);
      h = h ^ a ^ b ^ c;
      h = h ^ (h >> 16);
      h = h << 1;
      return h[IW-1:0] & IW'(ENTRIES - 1);
   endfunction

   function automatic logic [31:0] w(logic [127:0] k, int i);
      return k[127-32*i -: 32];
   endfunction

   function automatic logic [IW-1:0] ref_idx(logic [2:0] t, logic [127:0] s, logic [127:0] d, logic [31:0] p);
      logic [31:0] sh, dh;
      logic [15:0] sl, dl;
      sh = s[47:16]; sl = s[15:0]; dh = d[47:16]; dl = d[15:0];
      case (t)
         3'd2: return ref_mix({16'h0, sl} ^ {sh[15:0], 16'h0}, {16'h0, sh[31:16]} ^ {16'h0, dl}, dh);
         3'd0, 3'd1: return ref_mix(p, d[31:0], s[31:0]);
         3'd4, 3'd5: return ref_mix(w(s,3)^w(d,3)^p, w(s,2)^w(d,2)^w(d,0), w(s,1)^w(d,1)^w(s,0));
         default: return '1;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at falling edge, result visible at next falling edge
   task automatic issue(logic [2:0] t, logic [127:0] s, logic [127:0] d, logic [31:0] p);
      @(negedge clk);
      pkt_type = t; key_src = s; key_dst = d; key_ports = p; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_one(string req, logic [2:0] t, logic [127:0] s, logic [127:0] d, logic [31:0] p);
      issue(t, s, d, p);
      check(req, 32'(bucket_idx), 32'(ref_idx(t, s, d, p)));
      check(req, 32'(type_err), (t == 3 || t == 6 || t == 7) ? 1 : 0);
      check(req, 32'(out_valid), 1);
      if (!(t == 3 || t == 6 || t == 7)) check("R4", 32'(bucket_idx[0]), 0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R7", 32'(out_valid), 0);
      check("R7", 32'(bucket_idx), 0);
      check("R7", 32'(type_err), 0);
   endtask

   task automatic test_bridge();
      run_one("R1", 3'd2, 128'h0000_a1b2_c3d4_e5f6, 128'h0000_0102_0304_0506, 32'h0);
      run_one("R1", 3'd2, 128'h0000_ffff_0000_ffff, 128'h0000_0000_ffff_0000, 32'h0);
   endtask

   task automatic test_ipv4();
      run_one("R2", 3'd1, 128'hc0a8_0001, 128'h0a00_0002, 32'ha5a5_a506);
      run_one("R2", 3'd0, 128'h0102_0304, 128'h0506_0708, 32'h1234_0050);
      // single nonzero word: C=1 -> sel=1, rot=0x100, ^1 -> 0x101, fold 0x101, <<1 = 0x202
      issue(3'd0, 128'h1, 128'h0, 32'h0);
      check("R4", 32'(bucket_idx), 32'h202);
      // A=0x00010000: sel=0, mixed=0x10000, fold -> 0x10001, <<1 -> masked 0x2
      issue(3'd0, 128'h0, 128'h0, 32'h0001_0000);
      check("R4", 32'(bucket_idx), 32'h2);
   endtask

   task automatic test_ipv6();
      run_one("R3", 3'd4, 128'h2001_0db8_0000_0000_0000_0000_0000_0001,
              128'h2001_0db8_0000_0000_0000_0000_0000_0002, 32'ha5a5_a511);
      run_one("R3", 3'd5, 128'hfe80_0000_1111_2222_3333_4444_5555_6666,
              128'h0123_4567_89ab_cdef_0f1e_2d3c_4b5a_6978, 32'h1f90_0035);
   endtask

   task automatic test_unsupported();
      run_one("R5", 3'd3, 128'h1234, 128'h5678, 32'h9);
      run_one("R5", 3'd6, 128'h0, 128'h0, 32'h0);
      run_one("R5", 3'd7, 128'hffff, 128'h1, 32'h2);
   endtask

   task automatic test_hold();
      issue(3'd1, 128'h0a0a_0a0a, 128'h0b0b_0b0b, 32'h0);
      saved = bucket_idx;
      pkt_type = 3'd7; key_src = 128'hdead_beef;
      @(negedge clk);
      @(negedge clk);
      check("R6", 32'(out_valid), 0);
      check("R8", 32'(bucket_idx), 32'(saved));
      check("R8", 32'(type_err), 0);
   endtask

   task automatic test_ignored();
      issue(3'd1, 128'h0a0a_0a0a, 128'h0b0b_0b0b, 32'h77);
      saved = bucket_idx;
      issue(3'd1, {96'hffff_ffff_ffff_ffff_ffff_ffff, 32'h0a0a_0a0a},
            {96'h1234_5678_9abc_def0_1111_2222, 32'h0b0b_0b0b}, 32'h77);
      check("R9", 32'(bucket_idx), 32'(saved));
      issue(3'd2, 128'h0000_a1b2_c3d4_e5f6, 128'h0000_0102_0304_0506, 32'h0);
      saved = bucket_idx;
      issue(3'd2, 128'hffff_a1b2_c3d4_e5f6, 128'h5555_0102_0304_0506, 32'hffff_ffff);
      check("R9", 32'(bucket_idx), 32'(saved));
   endtask

   task automatic test_back_to_back();
      @(negedge clk);
      pkt_type = 3'd1; key_src = 128'h1; key_dst = 128'h2; key_ports = 32'h3; in_valid = 1'b1;
      @(negedge clk);
      check("R6", 32'(bucket_idx), 32'(ref_idx(3'd1, 128'h1, 128'h2, 32'h3)));
      pkt_type = 3'd6;
      @(negedge clk);
      in_valid = 1'b0;
      check("R6", 32'(type_err), 1);
      check("R6", 32'(out_valid), 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst = 1'b0;
      test_bridge();
      test_ipv4();
      test_ipv6();
      test_unsupported();
      test_hold();
      test_ignored();
      test_back_to_back();
      @(negedge clk);
      rst = 1'b1;
      test_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule